// File: doc/BRIEF.md
# Packet Endpoint Register Front End

This block sits between a processor register bus and a packet link. Software assembles an outgoing packet by writing 16-bit words into a transmit buffer. It then sets a flush bit in the control register. The block streams the buffered words out over a valid/ready interface and flags the final word. While the words go out, the block writes its own incrementing block counter into the low byte of header word 2.

On the receive side, words arrive over a valid/ready stream with first and last markers. When reception is enabled they are queued for the processor. Each read of the receive-data register returns the head word and pops it. The status register then shows whether that head word starts or ends its packet.

A packet is four header words followed by payload: target address, source address, {type, block counter}, and payload length in bytes. From this header the block checks two things:
- the block counter must strictly increase from one packet to the next;
- the packet must have as many words as the length field implies.

Error conditions are held in sticky status bits until software reads the status register. Transmit and receive events drive a maskable interrupt line.

Top module: `pkt_endpoint_regs`

## Requirements
- R1: Register select codes are 0 transmit data (write only, reads 0), 1 control, 2 receive data, 3 status, 4 local address, 5 remote address, 6 interrupt. Registers 4 and 5 are plain 16-bit read/write registers that reset to 0.
- R2: A write to register 0 appends a word to the transmit buffer. Status bit 0 is 1 while words are buffered and no send is in progress. Status bit 2 is 1 while the buffer holds TX_DEPTH words.
- R3: A write to register 0 while the buffer is full, or while a send is in progress, leaves the buffer unchanged and sets status bit 3.
- R4: Writing control with bit 15 set, while the buffer is not empty and idle, starts a send. Status bit 1 is then 1. The words leave in write order, one per tx_valid/tx_ready handshake, and tx_last is high on the final one. tx_data is held while tx_ready is low.
- R5: On the way out, the low byte of word index 2 is replaced by a hardware block counter. The counter is 1 after reset and increments once per completed packet.
- R6: With control bit 12 set, received words are queued. Status bit 15 shows a word is available; bit 13 and bit 12 give its first and last markers. A read of register 2 returns the word and pops it. rx_ready drops while the queue is full.
- R7: The low byte of received word index 2 must be greater than that of the previous packet; otherwise status bit 9 is set. The reference value is 0 after reset and whenever reception is disabled.
- R8: When a word marked last arrives, the packet's word count must equal 4 + ceil(L/2), where L is word index 3; otherwise status bit 8 is set.
- R9: With control bit 12 clear, rx_ready is 1 and incoming words are discarded. A discarded word marked first sets status bit 11.
- R10: link_err pulses set sticky status bits: bit 0 gives bit 4 (timeout), bit 1 gives bit 7 (distribution), bit 2 gives bit 10 (CRC).
- R11: Status bits 3, 4, 7, 8, 9 and 10 to 11 stay set until a read of register 3. That read clears them, except any set again in the same cycle.
- R12: Register 6 reads its interrupt sources in bits 8:5 and their enables in bits 3:0 (bit 0 enables bit 5, and so on):
  - bit 5 is set while the transmit buffer is empty and idle;
  - bit 6 latches on a completed send;
  - bit 7 latches when a received last word is queued;
  - bit 8 is set while receive data is available.
  Writing 1 to bit 6 or bit 7 clears it. irq is the OR of enabled sources.
- R13: Control reads return the receive-enable bit at position 12 and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers pop / sticky clear) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register (combinational) |
| tx_data | output | 16 | Outgoing stream word |
| tx_valid | output | 1 | Outgoing word valid |
| tx_last | output | 1 | Outgoing word is final of packet |
| tx_ready | input | 1 | Sink accepts outgoing word |
| rx_data | input | 16 | Incoming stream word |
| rx_first | input | 1 | Incoming word starts a packet |
| rx_last | input | 1 | Incoming word ends a packet |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Block accepts incoming word |
| link_err | input | 3 | Link error pulses: timeout, distribution, CRC |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted buffer pointer or count shows up on the stream ports within the next packet. It appears as a wrong word, a missing or misplaced tx_last, or a wrong receive-data value with a wrong first/last marker in the status register. A wrong block-counter or frame reference is visible on tx_data at word 2 of the very next send, or as status bit 9 after the next received header. Sticky-bit mistakes appear on the first status read after the event, or on the read that should have cleared them.

// File: rtl/pep_pkg.sv
// Shared constants for the packet endpoint register front end.
// Assumes a 16-bit register bus and 3-bit register select.
package pep_pkg;
    localparam int REG_W = 16;

    localparam logic [2:0] SEL_TXD   = 3'd0;
    localparam logic [2:0] SEL_CTRL  = 3'd1;
    localparam logic [2:0] SEL_RXD   = 3'd2;
    localparam logic [2:0] SEL_STAT  = 3'd3;
    localparam logic [2:0] SEL_LADDR = 3'd4;
    localparam logic [2:0] SEL_RADDR = 3'd5;
    localparam logic [2:0] SEL_IRQ   = 3'd6;

    localparam int CTL_RXEN  = 12;
    localparam int CTL_FLUSH = 15;

    localparam int ST_BUILD = 0;
    localparam int ST_SEND  = 1;
    localparam int ST_FULL  = 2;
    localparam int ST_TXERR = 3;
    localparam int ST_TMO   = 4;
    localparam int ST_DIST  = 7;
    localparam int ST_LEN   = 8;
    localparam int ST_FCNT  = 9;
    localparam int ST_CRC   = 10;
    localparam int ST_DROP  = 11;
    localparam int ST_LAST  = 12;
    localparam int ST_FIRST = 13;
    localparam int ST_AVAIL = 15;

    localparam int IRQ_EV_TX = 6;
    localparam int IRQ_EV_RX = 7;

    typedef struct packed {
        logic             first;
        logic             last;
        logic [REG_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/pep_word_fifo.sv
// Synchronous FIFO with occupancy count.
// Assumes DEPTH is a power of two; push only when not full, pop only when not empty.
module pep_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    // Storage write
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign rdata = mem[rp];
endmodule

// File: rtl/pep_rx_check.sv
// Per-packet receive checks: block counter strictly increasing and word count
// matching the byte length in header word 3. Counts words of accepted beats.
// Assumes beats arrive only while enabled; reference clears while disabled.
module pep_rx_check (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        beat,
    input  logic        first,
    input  logic        last,
    input  logic [15:0] data,
    output logic        fc_err,
    output logic        len_err
);
    logic [15:0] wcnt;
    logic [7:0]  ref_q;
    logic [15:0] len_q;
    logic [15:0] idx;
    logic [15:0] len_now;
    logic [16:0] need;

    // Word index of the current beat and the length it must reach
    always_comb begin
        idx     = first ? 16'd0 : wcnt;
        len_now = (idx == 16'd3) ? data : len_q;
        need    = 17'd4 + ((17'(len_now) + 17'd1) >> 1);
        fc_err  = beat && (idx == 16'd2) && (data[7:0] <= ref_q);
        len_err = beat && last && ((17'(idx) + 17'd1) != need);
    end

    // Track word position, counter reference and captured length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt  <= '0;
            ref_q <= '0;
            len_q <= '0;
        end else if (!enable) begin
            wcnt  <= '0;
            ref_q <= '0;
        end else if (beat) begin
            wcnt <= last ? 16'd0 : ((idx == 16'hFFFF) ? idx : idx + 16'd1);
            if (idx == 16'd2) ref_q <= data[7:0];
            if (idx == 16'd3) len_q <= data;
        end
    end
endmodule

// File: rtl/pkt_endpoint_regs.sv
// Register front end of a packet endpoint: transmit buffer with stream output,
// receive queue with first/last markers, sticky error status and interrupts.
// Assumes one register access per cycle and a sink/source obeying valid/ready.
module pkt_endpoint_regs
    import pep_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_sel,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic [15:0] tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic [15:0] rx_data,
    input  logic        rx_first,
    input  logic        rx_last,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [2:0]  link_err,
    output logic        irq
);
    localparam int TCW = $clog2(TX_DEPTH) + 1;
    localparam int RCW = $clog2(RX_DEPTH) + 1;
    localparam int RXW = $bits(rx_word_t);

    logic            wr_txd, wr_ctl, wr_irq, rd_rxd, rd_st;
    logic [15:0]     tx_head;
    logic [TCW-1:0]  tx_cnt, tx_idx;
    logic            tx_full, tx_empty, tx_push, tx_drop, tx_fire, tx_end;
    logic            sending, flush_go;
    logic [7:0]      tx_bc;
    logic            rx_en, rx_store, rx_pop, rx_full, rx_empty, rx_dropped;
    logic [RCW-1:0]  rx_cnt;
    rx_word_t        rx_in, rx_head;
    logic            fc_err, len_err;
    logic [15:0]     laddr, raddr, err_q, err_set, status, irq_reg;
    logic [3:0]      ie_q, irq_src;
    logic            ev_tx, ev_rx;

    // Decode register strobes
    always_comb begin
        wr_txd = wr_en && (reg_sel == SEL_TXD);
        wr_ctl = wr_en && (reg_sel == SEL_CTRL);
        wr_irq = wr_en && (reg_sel == SEL_IRQ);
        rd_rxd = rd_en && (reg_sel == SEL_RXD);
        rd_st  = rd_en && (reg_sel == SEL_STAT);
    end

    // Transmit path handshakes
    always_comb begin
        tx_full  = (tx_cnt == TCW'(TX_DEPTH));
        tx_empty = (tx_cnt == '0);
        tx_push  = wr_txd && !tx_full && !sending;
        tx_drop  = wr_txd && (tx_full || sending);
        tx_valid = sending && !tx_empty;
        tx_last  = tx_valid && (tx_cnt == TCW'(1));
        tx_fire  = tx_valid && tx_ready;
        tx_end   = tx_fire && tx_last;
        flush_go = wr_ctl && wdata[CTL_FLUSH] && !tx_empty && !sending;
        tx_data  = (tx_idx == TCW'(2)) ? {tx_head[15:8], tx_bc} : tx_head;
    end

    pep_word_fifo #(.W(16), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(wdata),
        .pop(tx_fire), .rdata(tx_head), .count(tx_cnt)
    );

    // Send sequencing, word index and hardware block counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sending <= 1'b0;
            tx_idx  <= '0;
            tx_bc   <= 8'd1;
        end else begin
            if (flush_go)    sending <= 1'b1;
            else if (tx_end) sending <= 1'b0;
            if (tx_end)       tx_idx <= '0;
            else if (tx_fire) tx_idx <= tx_idx + 1'b1;
            if (tx_end) tx_bc <= tx_bc + 8'd1;
        end
    end

    // Receive path acceptance
    always_comb begin
        rx_full    = (rx_cnt == RCW'(RX_DEPTH));
        rx_empty   = (rx_cnt == '0);
        rx_ready   = !rx_en || !rx_full;
        rx_store   = rx_valid && rx_ready && rx_en;
        rx_dropped = rx_valid && !rx_en && rx_first;
        rx_pop     = rd_rxd && !rx_empty;
        rx_in      = '{first: rx_first, last: rx_last, data: rx_data};
    end

    pep_word_fifo #(.W(RXW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_store), .wdata(rx_in),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt)
    );

    pep_rx_check u_rxchk (
        .clk(clk), .rst_n(rst_n), .enable(rx_en), .beat(rx_store),
        .first(rx_first), .last(rx_last), .data(rx_data),
        .fc_err(fc_err), .len_err(len_err)
    );

    // Collect error events for the sticky status bits
    always_comb begin
        err_set           = '0;
        err_set[ST_TXERR] = tx_drop;
        err_set[ST_TMO]   = link_err[0];
        err_set[ST_DIST]  = link_err[1];
        err_set[ST_LEN]   = len_err;
        err_set[ST_FCNT]  = fc_err;
        err_set[ST_CRC]   = link_err[2];
        err_set[ST_DROP]  = rx_dropped;
    end

    // Configuration, sticky errors and latched events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
            laddr <= '0;
            raddr <= '0;
            err_q <= '0;
            ie_q  <= '0;
            ev_tx <= 1'b0;
            ev_rx <= 1'b0;
        end else begin
            if (wr_ctl) rx_en <= wdata[CTL_RXEN];
            if (wr_en && reg_sel == SEL_LADDR) laddr <= wdata;
            if (wr_en && reg_sel == SEL_RADDR) raddr <= wdata;
            if (wr_irq) ie_q <= wdata[3:0];
            err_q <= (rd_st ? 16'd0 : err_q) | err_set;
            ev_tx <= tx_end | (ev_tx & ~(wr_irq & wdata[IRQ_EV_TX]));
            ev_rx <= (rx_store & rx_last) | (ev_rx & ~(wr_irq & wdata[IRQ_EV_RX]));
        end
    end

    // Status word, interrupt word and interrupt line
    always_comb begin
        status           = err_q;
        status[ST_BUILD] = !sending && !tx_empty;
        status[ST_SEND]  = sending;
        status[ST_FULL]  = tx_full;
        status[ST_LAST]  = !rx_empty && rx_head.last;
        status[ST_FIRST] = !rx_empty && rx_head.first;
        status[ST_AVAIL] = !rx_empty;
        irq_src          = {!rx_empty, ev_rx, ev_tx, tx_empty && !sending};
        irq_reg          = {7'd0, irq_src, 1'b0, ie_q};
        irq              = |(irq_src & ie_q);
    end

    // Read data multiplexer
    always_comb begin
        unique case (reg_sel)
            SEL_CTRL:  rdata = {3'd0, rx_en, 12'd0};
            SEL_RXD:   rdata = rx_empty ? 16'd0 : rx_head.data;
            SEL_STAT:  rdata = status;
            SEL_LADDR: rdata = laddr;
            SEL_RADDR: rdata = raddr;
            SEL_IRQ:   rdata = irq_reg;
            default:   rdata = 16'd0;
        endcase
    end
endmodule

// File: rtl/pep_checker.sv
// Temporal checks on the packet endpoint, attached through bind.
module pep_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [2:0]  reg_sel,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_last,
    input logic [15:0] tx_data,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        rx_first,
    input logic        rx_en,
    input logic        tx_full,
    input logic [15:0] err_q,
    input logic [15:0] err_set
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R4
    AST_FULL_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_sel == 3'd0 && tx_full |=> err_q[3]); // R3
    AST_DISABLED_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> rx_ready); // R9
    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_first && !rx_en |=> err_q[11]); // R9
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && reg_sel == 3'd3 && err_set == 16'd0 |=> err_q == 16'd0); // R11
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && reg_sel == 3'd3) |=> (err_q & $past(err_q)) == $past(err_q)); // R11
endmodule

bind pkt_endpoint_regs pep_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_first(rx_first), .rx_en(rx_en),
    .tx_full(tx_full), .err_q(err_q), .err_set(err_set)
);

// File: tb/sim_pkt_endpoint_regs.sv
`timescale 1ns/1ps
module sim_pkt_endpoint_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0, rdata;
    logic [15:0] tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_first = 1'b0, rx_last = 1'b0, rx_valid = 1'b0;
    logic        rx_ready;
    logic [2:0]  link_err = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] v;
    logic [7:0]  bc = 8'd1;
    localparam logic [15:0] ERRM = 16'h0F98;

    always #10 clk = ~clk;

    pkt_endpoint_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_last(tx_last), .tx_ready(tx_ready), .rx_data(rx_data), .rx_first(rx_first),
        .rx_last(rx_last), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .link_err(link_err), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        reg_sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] d);
        reg_sel = s; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] s, output logic [15:0] d);
        reg_sel = s;
        #1 d = rdata;
    endtask

    function automatic logic [15:0] rxw(input int i, input logic [7:0] b, input logic [15:0] len);
        if (i == 0) return 16'h1100;
        if (i == 1) return 16'h2200;
        if (i == 2) return {8'h33, b};
        if (i == 3) return len;
        return 16'h4000 + 16'(i);
    endfunction

    task automatic send_pkt(input int n, input logic [7:0] b, input logic [15:0] len);
        for (int i = 0; i < 4 + n; i++) begin
            rx_data = rxw(i, b, len); rx_first = (i == 0); rx_last = (i == 3 + n);
            rx_valid = 1'b1;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
    endtask

    task automatic drain(input int n, input logic [7:0] b, input logic [15:0] len);
        logic [15:0] s, d;
        for (int k = 0; k < 4 + n; k++) begin
            peek(3'd3, s);
            chk("R6 avail", s[15], 1'b1);
            chk("R6 first", s[13], k == 0);
            chk("R6 last", s[12], k == 3 + n);
            rd(3'd2, d);
            chk("R6 data", d, rxw(k, b, len));
        end
        peek(3'd3, s);
        chk("R6 empty", s[15], 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        peek(3'd3, v); chk("R2 reset status", v, 16'h0000);
        peek(3'd6, v); chk("R12 reset irq reg", v, 16'h0020);
        chk("R12 reset irq", irq, 1'b0);
        chk("R4 reset tx_valid", tx_valid, 1'b0);
        peek(3'd4, v); chk("R1 reset laddr", v, 16'h0000);
        peek(3'd0, v); chk("R1 txd reads zero", v, 16'h0000);
        // Address registers and control
        wr(3'd4, 16'hBEEF); wr(3'd5, 16'h1234);
        peek(3'd4, v); chk("R1 laddr", v, 16'hBEEF);
        peek(3'd5, v); chk("R1 raddr", v, 16'h1234);
        wr(3'd1, 16'hFFFF); peek(3'd1, v); chk("R13 ctrl read", v, 16'h1000);
        wr(3'd1, 16'h0000); peek(3'd1, v); chk("R13 ctrl clear", v, 16'h0000);

        // Transmit sweep over every packet length
        for (int n = 1; n <= 8; n++) begin
            int k, cyc;
            tx_ready = 1'b0;
            for (int i = 0; i < n; i++) wr(3'd0, 16'(n * 256 + i * 16 + 3));
            peek(3'd3, v);
            chk("R2 building", v[0], 1'b1);
            chk("R2 full", v[2], n == 8);
            if (n == 8) begin
                wr(3'd0, 16'hDEAD);
                peek(3'd3, v); chk("R3 overflow err", v[3], 1'b1);
                rd(3'd3, v);
                peek(3'd3, v); chk("R11 cleared by read", v & ERRM, 16'h0000);
            end
            wr(3'd1, 16'h8000);
            peek(3'd3, v);
            chk("R4 sending", v[1], 1'b1);
            chk("R2 not building", v[0], 1'b0);
            if (n == 3) begin
                wr(3'd0, 16'hFFFF);
                peek(3'd3, v); chk("R3 write while sending", v[3], 1'b1);
                rd(3'd3, v);
            end
            k = 0; cyc = 0;
            while (k < n && cyc < 200) begin
                tx_ready = (cyc % 3) != 2;
                #1;
                if (tx_valid && tx_ready) begin
                    logic [15:0] w;
                    w = 16'(n * 256 + k * 16 + 3);
                    if (k == 2) chk("R5 block counter", tx_data, {w[15:8], bc});
                    else chk("R4 tx word", tx_data, w);
                    chk("R4 tx_last", tx_last, k == n - 1);
                    k++;
                end
                @(negedge clk);
                cyc++;
            end
            tx_ready = 1'b0;
            chk("R4 word count", k, n);
            chk("R4 idle after", tx_valid, 1'b0);
            peek(3'd3, v); chk("R4 send done", v[1:0], 2'b00);
            peek(3'd6, v); chk("R12 tx event", v[6], 1'b1);
            wr(3'd6, 16'h0040);
            peek(3'd6, v); chk("R12 tx event cleared", v[6], 1'b0);
            bc = bc + 8'd1;
        end

        // Interrupt line from transmit event and buffer-free status
        wr(3'd6, 16'h0002);
        wr(3'd0, 16'h0101);
        wr(3'd1, 16'h8000);
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
        #1 chk("R12 irq on tx event", irq, 1'b1);
        wr(3'd6, 16'h0042);
        #1 chk("R12 irq after clear", irq, 1'b0);
        wr(3'd6, 16'h0001);
        #1 chk("R12 irq tx free", irq, 1'b1);
        wr(3'd6, 16'h0000);

        // Receive sweep
        wr(3'd1, 16'h1000);
        for (int n = 0; n <= 4; n++) begin
            send_pkt(n, 8'(n + 1), 16'(2 * n));
            peek(3'd3, v); chk("R8 no error", v & ERRM, 16'h0000);
            peek(3'd6, v); chk("R12 rx event and avail", v[8:7], 2'b11);
            drain(n, 8'(n + 1), 16'(2 * n));
            wr(3'd6, 16'h0080);
            peek(3'd6, v); chk("R12 rx event cleared", v[8:7], 2'b00);
        end
        wr(3'd6, 16'h0008);
        send_pkt(0, 8'd6, 16'd0);
        #1 chk("R12 irq rx avail", irq, 1'b1);
        drain(0, 8'd6, 16'd0);
        #1 chk("R12 irq rx drained", irq, 1'b0);
        wr(3'd6, 16'h0000);
        // Repeated block counter
        send_pkt(1, 8'd6, 16'd2);
        peek(3'd3, v); chk("R7 frame counter err", v & ERRM, 16'h0200);
        drain(1, 8'd6, 16'd2);
        rd(3'd3, v);
        send_pkt(1, 8'd7, 16'd2);
        peek(3'd3, v); chk("R7 increasing ok", v & ERRM, 16'h0000);
        drain(1, 8'd7, 16'd2);
        // Length checks
        send_pkt(2, 8'd8, 16'd3);
        peek(3'd3, v); chk("R8 odd length ok", v & ERRM, 16'h0000);
        drain(2, 8'd8, 16'd3);
        send_pkt(2, 8'd9, 16'd6);
        peek(3'd3, v); chk("R8 length err", v & ERRM, 16'h0100);
        drain(2, 8'd9, 16'd6);
        rd(3'd3, v);
        // Reference reset by disabling reception
        wr(3'd1, 16'h0000); wr(3'd1, 16'h1000);
        send_pkt(0, 8'd1, 16'd0);
        peek(3'd3, v); chk("R7 ref reset", v & ERRM, 16'h0000);
        drain(0, 8'd1, 16'd0);
        // Backpressure when queue fills
        send_pkt(4, 8'd2, 16'd8);
        #1 chk("R6 rx_ready low when full", rx_ready, 1'b0);
        drain(4, 8'd2, 16'd8);
        #1 chk("R6 rx_ready after drain", rx_ready, 1'b1);
        // Disabled reception discards
        wr(3'd1, 16'h0000);
        #1 chk("R9 ready when disabled", rx_ready, 1'b1);
        send_pkt(2, 8'd3, 16'd4);
        peek(3'd3, v);
        chk("R9 dropped flag", v & ERRM, 16'h0800);
        chk("R9 nothing queued", v[15], 1'b0);
        rd(3'd3, v);
        // Link error pulses
        link_err = 3'b111; @(negedge clk); link_err = 3'b000;
        peek(3'd3, v); chk("R10 link errors", v & ERRM, 16'h0490);
        @(negedge clk);
        peek(3'd3, v); chk("R11 sticky held", v & ERRM, 16'h0490);
        rd(3'd3, v);
        peek(3'd3, v); chk("R11 cleared", v & ERRM, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule